// File: doc/BRIEF.md
# DDR SDRAM Power-Up Command Sequencer

This block takes a DDR SDRAM array from power-up to normal operation without software involvement. One start pulse makes it walk a fixed list of fourteen memory commands: a no-operation, a precharge of all banks, an extended mode-register write, a mode-register write that resets the DLL, a second precharge, eight auto-refreshes and a final mode-register write without the DLL reset. Each command goes to every populated rank. Between two steps the block waits a programmable number of clock cycles, given by the clock frequency in MHz times the wait in microseconds. It then signals a switch to normal mode and raises an initialization-complete flag.

Ranks are described by their end boundaries in 32 MB units. A rank is populated when its end boundary is above the end of the rank before it. A command reaches a rank as a strobe carrying the command code and an address. The address is the rank's base, which is its start boundary shifted left by 25, plus the mode word for mode-register writes. The mode word is moved onto shifted host address lines. A typical operating mode word is 0x06A: burst length 4, interleaved order, CAS latency 2.5.

Top module: `ddr_init_seq`

## Requirements
- R1: After reset, cmdValid and done are both low.
- R2: Command codes are NOP=1, precharge-all=2, mode-register write=3, extended mode-register write=4, auto-refresh=6 and normal=7. Self-refresh (0) and 5 are never issued. The step order is NOP, precharge, extended mode write, mode write, precharge, eight auto-refreshes, mode write.
- R3: Within each step, ranks are scanned in order 0 to NUM_RANKS-1 with a running start that begins at 0. Rank r (bits r*BOUND_W +: BOUND_W of rankEnds) gets a strobe only when its end is greater than the running start, and the running start then becomes that end. The address base is the running start shifted left by 25, truncated to ADDR_W bits.
- R4: For codes 3 and 4, mode-word bit 11 appears on address bit 13 and mode-word bits 9:0 appear on address bits 12:3. Mode-word bit 10 and address bits 2:0 and 24:14 are zero. For every other code, address bits 24:0 are zero.
- R5: The extended mode write carries extModeWord unchanged. The first mode write carries modeWord with bit 8 (DLL reset) set. The last mode write carries modeWord with bit 8 cleared.
- R6: The strobe for rank r of the first step appears r+1 cycles after the clock edge that samples startPulse. Each step takes NUM_RANKS scan cycles followed by CLK_MHZ*WAIT_US idle cycles.
- R7: After the last step's wait, exactly one strobe with code 7 and address 0 is issued. It is not sent per rank, and it is issued even when every rank is empty.
- R8: done rises in the cycle after the code-7 strobe. It stays high until a new startPulse, which clears it one cycle later.
- R9: A startPulse while a sequence is running is ignored, and the command trace is unchanged.
- R10: No strobe occurs while done is high or while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startPulse | input | 1 | Starts a sequence when the block is idle |
| rankEnds | input | NUM_RANKS*BOUND_W | Per-rank end boundaries in 32 MB units |
| modeWord | input | 12 | Operating mode-register value |
| extModeWord | input | 12 | Extended mode-register value |
| cmdValid | output | 1 | Command strobe |
| cmdCode | output | 3 | Command code |
| cmdAddr | output | ADDR_W | Command address |
| done | output | 1 | Initialization complete |

## Verification
Every output is registered, so the result of the edge that samples startPulse is visible one cycle later. Rank r's strobe for step s follows that edge by 1 + s*(NUM_RANKS + wait) + r cycles. The code-7 strobe follows the fourteenth wait, and done comes one cycle after it. The bench drives inputs on falling edges and builds a per-cycle queue of expected outputs from these counts. It compares strobe, code, address and done against the head of that queue at every falling edge, across populated, sparse, empty and decreasing rank layouts and a mid-run start pulse.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  typedef enum logic [2:0] {
    CMD_SELF   = 3'd0,
    CMD_NOP    = 3'd1,
    CMD_PRE    = 3'd2,
    CMD_MRS    = 3'd3,
    CMD_EMRS   = 3'd4,
    CMD_CBR    = 3'd6,
    CMD_NORMAL = 3'd7
  } cmd_e;

  localparam int MODE_W        = 12;
  localparam int NUM_STEPS     = 14;
  localparam int STEP_W        = $clog2(NUM_STEPS);
  localparam int DLL_RESET_BIT = 8;
  localparam int BASE_SHIFT    = 25;

  // strobes from control to datapath
  typedef struct packed {
    logic clearRun;
    logic scan;
    logic emitNorm;
    logic setDone;
    logic clrDone;
    logic dllRst;
    cmd_e cmd;
  } seq_ctl_t;

  function automatic cmd_e stepCmd(input logic [STEP_W-1:0] idx);
    cmd_e c;
    case (idx)
      4'd0:    c = CMD_NOP;
      4'd1:    c = CMD_PRE;
      4'd2:    c = CMD_EMRS;
      4'd3:    c = CMD_MRS;
      4'd4:    c = CMD_PRE;
      4'd13:   c = CMD_MRS;
      default: c = CMD_CBR;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/ddr_init_ctrl.sv
module ddr_init_ctrl
  import ddr_init_pkg::*;
#(
  parameter int NUM_RANKS = 4,
  parameter int WAIT_CYC  = 20000,
  localparam int RIDX_W   = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1,
  localparam int WCNT_W   = $clog2(WAIT_CYC + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  output seq_ctl_t          ctl,
  output logic [RIDX_W-1:0] rankIdx
);

  typedef enum logic [2:0] {S_IDLE, S_SCAN, S_WAIT, S_NORM, S_FIN} state_e;

  state_e            state;
  logic [STEP_W-1:0] stepIdx;
  logic [WCNT_W-1:0] waitCnt;

  localparam logic [RIDX_W-1:0] LAST_RANK = RIDX_W'(NUM_RANKS - 1);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);
  localparam logic [WCNT_W-1:0] LAST_WAIT = WCNT_W'(WAIT_CYC - 1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      stepIdx <= '0;
      rankIdx <= '0;
      waitCnt <= '0;
    end else begin
      case (state)
        S_IDLE: if (startPulse) begin
          state   <= S_SCAN;
          stepIdx <= '0;
          rankIdx <= '0;
        end
        S_SCAN: if (rankIdx == LAST_RANK) begin
          state   <= S_WAIT;
          waitCnt <= '0;
        end else begin
          rankIdx <= rankIdx + 1'b1;
        end
        S_WAIT: if (waitCnt == LAST_WAIT) begin
          rankIdx <= '0;
          if (stepIdx == LAST_STEP) begin
            state <= S_NORM;
          end else begin
            stepIdx <= stepIdx + 1'b1;
            state   <= S_SCAN;
          end
        end else begin
          waitCnt <= waitCnt + 1'b1;
        end
        S_NORM:  state <= S_FIN;
        S_FIN:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.clearRun = (state == S_WAIT) || (state == S_IDLE && startPulse);
    ctl.scan     = (state == S_SCAN);
    ctl.emitNorm = (state == S_NORM);
    ctl.setDone  = (state == S_FIN);
    ctl.clrDone  = (state == S_IDLE) && startPulse;
    ctl.dllRst   = (stepIdx == STEP_W'(3));
    ctl.cmd      = stepCmd(stepIdx);
  end

endmodule

// File: rtl/ddr_init_dpath.sv
module ddr_init_dpath
  import ddr_init_pkg::*;
#(
  parameter int NUM_RANKS = 4,
  parameter int BOUND_W   = 8,
  parameter int ADDR_W    = 32,
  localparam int RIDX_W   = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  seq_ctl_t                     ctl,
  input  logic [RIDX_W-1:0]            rankIdx,
  input  logic [NUM_RANKS*BOUND_W-1:0] rankEnds,
  input  logic [MODE_W-1:0]            modeWord,
  input  logic [MODE_W-1:0]            extModeWord,
  output logic                         cmdValid,
  output logic [2:0]                   cmdCode,
  output logic [ADDR_W-1:0]            cmdAddr,
  output logic                         done
);

  logic [BOUND_W-1:0] endArr [NUM_RANKS];
  logic [BOUND_W-1:0] runStart;
  logic [BOUND_W-1:0] endSel;
  logic               hit;
  logic [MODE_W-1:0]  word;
  logic [ADDR_W-1:0]  mapped;
  logic [ADDR_W-1:0]  base;

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_unpack
    assign endArr[r] = rankEnds[r*BOUND_W +: BOUND_W];
  end

  always_comb begin
    endSel = endArr[rankIdx];
    hit    = endSel > runStart;
    base   = ADDR_W'(runStart) << BASE_SHIFT;
    if (ctl.cmd == CMD_EMRS)
      word = extModeWord;
    else if (ctl.dllRst)
      word = modeWord | (MODE_W'(1) << DLL_RESET_BIT);
    else
      word = modeWord & ~(MODE_W'(1) << DLL_RESET_BIT);
    if (ctl.cmd == CMD_MRS || ctl.cmd == CMD_EMRS)
      mapped = ADDR_W'({word[11], word[9:0], 3'b000});
    else
      mapped = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runStart <= '0;
      cmdValid <= 1'b0;
      cmdCode  <= 3'd0;
      cmdAddr  <= '0;
      done     <= 1'b0;
    end else begin
      cmdValid <= 1'b0;
      if (ctl.clearRun) runStart <= '0;
      if (ctl.scan && hit) begin
        cmdValid <= 1'b1;
        cmdCode  <= ctl.cmd;
        cmdAddr  <= base + mapped;
        runStart <= endSel;
      end
      if (ctl.emitNorm) begin
        cmdValid <= 1'b1;
        cmdCode  <= CMD_NORMAL;
        cmdAddr  <= '0;
      end
      if (ctl.clrDone)      done <= 1'b0;
      else if (ctl.setDone) done <= 1'b1;
    end
  end

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int NUM_RANKS = 4,
  parameter int BOUND_W   = 8,
  parameter int ADDR_W    = 32,
  parameter int CLK_MHZ   = 100,
  parameter int WAIT_US   = 200,
  localparam int WAIT_CYC = CLK_MHZ * WAIT_US,
  localparam int RIDX_W   = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         startPulse,
  input  logic [NUM_RANKS*BOUND_W-1:0] rankEnds,
  input  logic [11:0]                  modeWord,
  input  logic [11:0]                  extModeWord,
  output logic                         cmdValid,
  output logic [2:0]                   cmdCode,
  output logic [ADDR_W-1:0]            cmdAddr,
  output logic                         done
);

  seq_ctl_t          ctl;
  logic [RIDX_W-1:0] rankIdx;

  ddr_init_ctrl #(.NUM_RANKS(NUM_RANKS), .WAIT_CYC(WAIT_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse),
    .ctl(ctl), .rankIdx(rankIdx)
  );

  ddr_init_dpath #(.NUM_RANKS(NUM_RANKS), .BOUND_W(BOUND_W), .ADDR_W(ADDR_W)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rankIdx(rankIdx),
    .rankEnds(rankEnds), .modeWord(modeWord), .extModeWord(extModeWord),
    .cmdValid(cmdValid), .cmdCode(cmdCode), .cmdAddr(cmdAddr), .done(done)
  );

endmodule

// File: rtl/ddr_init_seq_chk.sv
module ddr_init_seq_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              startPulse,
  input logic              cmdValid,
  input logic [2:0]        cmdCode,
  input logic [ADDR_W-1:0] cmdAddr,
  input logic              done
);

  p_code_legal_r2: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> (cmdCode != 3'd0 && cmdCode != 3'd5));

  p_plain_addr_r4: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !(cmdCode == 3'd3 || cmdCode == 3'd4) |-> cmdAddr[24:0] == 25'd0);

  p_mode_addr_r4: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && (cmdCode == 3'd3 || cmdCode == 3'd4)
      |-> (cmdAddr[2:0] == 3'd0 && cmdAddr[24:14] == 11'd0));

  p_norm_addr_r7: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdCode == 3'd7 |-> cmdAddr == '0);

  p_norm_done_r8: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdCode == 3'd7 |=> done && !cmdValid);

  p_done_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    done && !startPulse |=> done);

  p_done_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    done && startPulse |=> !done);

  p_quiet_done_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !cmdValid);

endmodule

bind ddr_init_seq ddr_init_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .startPulse(startPulse), .cmdValid(cmdValid),
  .cmdCode(cmdCode), .cmdAddr(cmdAddr), .done(done)
);

// File: tb/test_ddr_init_seq.sv
module test_ddr_init_seq;

  localparam int NR = 4;
  localparam int BW = 8;
  localparam int AW = 32;
  localparam int WAITC = 2 * 5;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startPulse = 1'b0;
  logic [NR*BW-1:0] rankEnds = '0;
  logic [11:0]   modeWord = 12'h06A;
  logic [11:0]   extModeWord = 12'h000;
  logic          cmdValid;
  logic [2:0]    cmdCode;
  logic [AW-1:0] cmdAddr;
  logic          done;

  int checks = 0;
  int errors = 0;

  bit          qV[$];
  int          qC[$];
  logic [31:0] qA[$];

  int stepCodes[14] = '{1, 2, 4, 3, 2, 6, 6, 6, 6, 6, 6, 6, 6, 3};

  always #5 clk = ~clk;

  ddr_init_seq #(.NUM_RANKS(NR), .BOUND_W(BW), .ADDR_W(AW),
                 .CLK_MHZ(2), .WAIT_US(5)) i_ddr_init_seq (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .rankEnds(rankEnds),
    .modeWord(modeWord), .extModeWord(extModeWord), .cmdValid(cmdValid),
    .cmdCode(cmdCode), .cmdAddr(cmdAddr), .done(done)
  );

  task automatic push(bit v, int c, logic [31:0] a);
    qV.push_back(v); qC.push_back(c); qA.push_back(a);
  endtask

  // expected per-cycle trace from the requirements
  task automatic buildExpected(logic [7:0] e [4], logic [11:0] mw, logic [11:0] ew);
    push(0, 0, 0);                       // R6: first cycle after start edge
    for (int s = 0; s < 14; s++) begin
      int code = stepCodes[s];           // R2
      int w = 0;
      int mapped = 0;
      int run = 0;
      if (code == 4) w = ew;             // R5
      else if (code == 3 && s == 3) w = mw | 'h100;
      else if (code == 3) w = mw & ~'h100;
      if (code == 3 || code == 4)
        mapped = (((w >> 11) & 1) << 13) | ((w & 'h3FF) << 3);  // R4
      for (int r = 0; r < NR; r++) begin
        if (int'(e[r]) > run) begin      // R3
          push(1, code, 32'((run << 25) + mapped));
          run = e[r];
        end else begin
          push(0, 0, 0);
        end
      end
      for (int k = 0; k < WAITC; k++) push(0, 0, 0);
    end
    push(1, 7, 0);                       // R7
  endtask

  task automatic cmpCycle(string tag, bit eV, int eC, logic [31:0] eA, bit eD);
    checks++;
    if (done !== eD) begin
      errors++;
      $display("FAIL %s R8: done actual=%0b expected=%0b", tag, done, eD);
    end else if (cmdValid !== eV) begin
      errors++;
      $display("FAIL %s R3 R6 R10: cmdValid actual=%0b expected=%0b", tag, cmdValid, eV);
    end else if (eV && cmdCode !== 3'(eC)) begin
      errors++;
      $display("FAIL %s %s: cmdCode actual=%0d expected=%0d", tag,
               (eC == 7) ? "R7" : "R2", cmdCode, eC);
    end else if (eV && cmdAddr !== eA) begin
      errors++;
      $display("FAIL %s %s: cmdAddr actual=%h expected=%h", tag,
               (eC == 3 || eC == 4) ? "R4 R5" : ((eC == 7) ? "R7" : "R3"), cmdAddr, eA);
    end
  endtask

  task automatic runCase(string tag, logic [7:0] e [4], logic [11:0] mw,
                         logic [11:0] ew, bit midStart);
    for (int r = 0; r < NR; r++) rankEnds[r*BW +: BW] = e[r];
    modeWord = mw;
    extModeWord = ew;
    qV.delete(); qC.delete(); qA.delete();
    buildExpected(e, mw, ew);
    @(negedge clk); startPulse = 1'b1;
    @(negedge clk); startPulse = 1'b0;
    for (int i = 0; i < qV.size(); i++) begin
      cmpCycle(tag, qV[i], qC[i], qA[i], 1'b0);
      startPulse = (midStart && i == 20);  // R9: ignored while running
      @(negedge clk);
    end
    startPulse = 1'b0;
    for (int k = 0; k < 4; k++) begin      // R8 R10: done held, no strobes
      cmpCycle(tag, 1'b0, 0, 0, 1'b1);
      @(negedge clk);
    end
  endtask

  initial begin
    logic [7:0] e [4];
    repeat (3) @(negedge clk);
    checks++;                              // R1
    if (cmdValid !== 1'b0 || done !== 1'b0) begin
      errors++;
      $display("FAIL R1: reset outputs actual v=%0b d=%0b expected v=0 d=0", cmdValid, done);
    end
    rstN = 1'b1;
    @(negedge clk);
    e = '{8'd1, 8'd2, 8'd3, 8'd4};
    runCase("all ranks", e, 12'h06A, 12'h000, 1'b0);
    e = '{8'd4, 8'd4, 8'd8, 8'd8};
    runCase("sparse ranks", e, 12'h06A, 12'h002, 1'b0);
    e = '{8'd0, 8'd0, 8'd0, 8'd0};
    runCase("empty ranks", e, 12'h06A, 12'h000, 1'b0);
    e = '{8'd0, 8'd16, 8'd16, 8'd200};
    runCase("R9 high bounds mid start", e, 12'hC55, 12'hFFF, 1'b1);
    e = '{8'd8, 8'd4, 8'd2, 8'd1};
    runCase("decreasing bounds", e, 12'h7AA, 12'h401, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule